// File: doc/BRIEF.md
# Trailing-Edge Ramp PWM Generator

This block drives the single power switch of a forward converter. A free-running counter forms a rising sawtooth carrier whose length, in clock cycles, comes from a period input. Each period the output rises on the first count and falls once the carrier passes the active on-time. Only the falling edge moves with the command. The output is registered, so the pin carries no comparator glitches.

The on-time command arrives as a small stream and is shaped once per period. A command inside the dead zone, below 2% of the period, gives no pulse at all rather than a sliver. A command above the 40% duty ceiling is cut down to that ceiling. Both the command and the period are taken only when the carrier wraps, so a pulse that is already running is never changed. A one-cycle strobe marks the first cycle of every period so that a compensator can align its sampling to the carrier. The default period is 2000 cycles, which gives 125 kHz from a 250 MHz clock.

Command stream rules: `cmd_ready_o` is held high at all times, so the block never applies back-pressure. Every cycle with `cmd_valid_i` high is a completed transfer. When several transfers fall within one period, the last one wins.

Top module: `pwm_trail_gen`

## Requirements
- R1: While `rst` is high, `pwm_o` and `start_o` are low. The first clock edge after `rst` falls begins a period, so `start_o` is high in the first cycle after release.
- R2: A period lasts max(`period_i`, 2) clock cycles. `period_i` is sampled only at the edge that begins the period. `start_o` is high in exactly the first cycle of each period and is never high in two adjacent cycles.
- R3: Within a period `pwm_o` is high for a run of L cycles that starts in the first cycle, and low for the rest. It never rises in a cycle other than the first cycle of a period.
- R4: `cmd_ready_o` is always 1. A period uses the last command accepted at or before the edge that begins it, including a transfer on that same edge. A transfer made during a period does not change that period's pulse.
- R5: With period P and command C, if C*100 < P*2 then L = 0 and `pwm_o` stays low for the whole period. This covers C = 0.
- R6: L never exceeds ceil(40*P/100). A command above that limit gives exactly that limit.
- R7: A command with C*100 >= P*2 and C <= ceil(40*P/100) gives L = C.
- R8: A `period_i` value of 0 or 1 is treated as 2, which gives a two-cycle period with at most one high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid_i | input | 1 | On-time command valid |
| cmd_ready_o | output | 1 | On-time command ready (always 1) |
| cmd_data_i | input | CNT_W | On-time command, in clock cycles |
| period_i | input | CNT_W | Carrier period, in clock cycles |
| pwm_o | output | 1 | Gate-drive pulse, registered |
| start_o | output | 1 | One-cycle strobe in the first cycle of each period |

## Verification
The bench builds the block with CNT_W = 16, a 2% dead zone, a 40% ceiling and a reset period of 200 cycles, then drives periods of 1, 50, 100 and 250 cycles through the port. At a period of 100, the dead-zone edge falls between commands 1 and 2 and the ceiling lands exactly on 40. Commands of 40, 41 and 90 therefore probe the clamp from both sides. At 250 the threshold and the limit differ again, and a period input of 1 reaches the smallest legal carrier. Short periods keep each case to a few hundred cycles, which leaves room for checks of mid-period and repeated command transfers.

// File: rtl/pwm_trail_pkg.sv
package pwm_trail_pkg;
  localparam int unsigned PCT_FULL    = 100;
  localparam int unsigned DZ_PCT_DEF  = 2;
  localparam int unsigned MAX_PCT_DEF = 40;
  localparam int unsigned MIN_PERIOD  = 2;
  localparam int unsigned PCT_BITS    = 7;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } pwm_phase_e;
endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier
  import pwm_trail_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DEF_PERIOD = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_i,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_nx_o,
  output logic [CNT_W-1:0] per_nx_o,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] per_q_o
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] DEF_P = CNT_W'(DEF_PERIOD);

  logic [CNT_W-1:0] cnt_q, per_q, per_sel;

  always_comb begin
    per_sel  = (period_i < MIN_P) ? MIN_P : period_i;
    wrap_o   = (cnt_q == per_q - ONE);
    cnt_nx_o = wrap_o ? '0 : cnt_q + ONE;
    per_nx_o = wrap_o ? per_sel : per_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= DEF_P - ONE;
      per_q <= DEF_P;
    end else begin
      cnt_q <= cnt_nx_o;
      per_q <= per_nx_o;
    end
  end

  assign cnt_q_o = cnt_q;
  assign per_q_o = per_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < per_q);

  // R8
  per_floor_chk: assert property (@(posedge clk) disable iff (rst)
    per_q >= MIN_P);
endmodule

// File: rtl/pwm_cmd_shaper.sv
module pwm_cmd_shaper
  import pwm_trail_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DZ_PCT = DZ_PCT_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [CNT_W-1:0] cmd_data_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] per_nx_i,
  output logic [CNT_W-1:0] cmd_nx_o,
  output logic             sup_nx_o,
  output logic [CNT_W-1:0] cmd_q_o,
  output logic             sup_q_o
);
  localparam int unsigned PW = CNT_W + PCT_BITS;

  logic [CNT_W-1:0] pend_q, cmd_q, cmd_sel;
  logic             sup_q, in_dz;

  assign cmd_ready_o = 1'b1;
  assign cmd_sel     = cmd_valid_i ? cmd_data_i : pend_q;

  generate
    if (DZ_PCT == 0) begin : g_no_dz
      assign in_dz = (cmd_sel == '0);
    end else begin : g_dz
      logic [PW-1:0] cmd_scaled, dz_edge;
      assign cmd_scaled = PW'(cmd_sel) * PW'(PCT_FULL);
      assign dz_edge    = PW'(per_nx_i) * PW'(DZ_PCT);
      assign in_dz      = (cmd_scaled < dz_edge);
    end
  endgenerate

  always_comb begin
    cmd_nx_o = wrap_i ? cmd_sel : cmd_q;
    sup_nx_o = wrap_i ? in_dz : sup_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      cmd_q  <= '0;
      sup_q  <= 1'b1;
    end else begin
      if (cmd_valid_i) pend_q <= cmd_data_i;
      cmd_q <= cmd_nx_o;
      sup_q <= sup_nx_o;
    end
  end

  assign cmd_q_o = cmd_q;
  assign sup_q_o = sup_q;

  // R5
  zero_sup_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == '0) |-> sup_q);
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_trail_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MAX_PCT = MAX_PCT_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_nx_i,
  input  logic [CNT_W-1:0] per_nx_i,
  input  logic [CNT_W-1:0] cmd_nx_i,
  input  logic             sup_nx_i,
  output logic             pwm_o,
  output logic             start_o
);
  localparam int unsigned PW = CNT_W + PCT_BITS;

  pwm_phase_e    ph_q, ph_nx;
  logic          start_q;
  logic          below_cmd, below_lim;
  logic [PW-1:0] cnt_scaled, lim_edge;

  always_comb begin
    cnt_scaled = PW'(cnt_nx_i) * PW'(PCT_FULL);
    lim_edge   = PW'(per_nx_i) * PW'(MAX_PCT);
    below_cmd  = (cnt_nx_i < cmd_nx_i);
    below_lim  = (cnt_scaled < lim_edge);
    ph_nx      = (!sup_nx_i && below_cmd && below_lim) ? PH_HIGH : PH_LOW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_LOW;
      start_q <= 1'b0;
    end else begin
      ph_q    <= ph_nx;
      start_q <= wrap_i;
    end
  end

  assign pwm_o   = (ph_q == PH_HIGH);
  assign start_o = start_q;

  // R3
  rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_o) |-> start_o);

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
endmodule

// File: rtl/pwm_trail_gen.sv
module pwm_trail_gen
  import pwm_trail_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DEF_PERIOD = 2000,
  parameter int unsigned DZ_PCT     = DZ_PCT_DEF,
  parameter int unsigned MAX_PCT    = MAX_PCT_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [CNT_W-1:0] cmd_data_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             pwm_o,
  output logic             start_o
);
  localparam int unsigned PW = CNT_W + PCT_BITS;

  logic             wrap;
  logic [CNT_W-1:0] cnt_nx, per_nx, cnt_q, per_q;
  logic [CNT_W-1:0] cmd_nx, cmd_q;
  logic             sup_nx, sup_q;

  pwm_carrier #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_carrier (
    .clk(clk), .rst(rst), .period_i(period_i), .wrap_o(wrap),
    .cnt_nx_o(cnt_nx), .per_nx_o(per_nx), .cnt_q_o(cnt_q), .per_q_o(per_q)
  );

  pwm_cmd_shaper #(.CNT_W(CNT_W), .DZ_PCT(DZ_PCT)) u_shaper (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_data_i(cmd_data_i), .wrap_i(wrap), .per_nx_i(per_nx),
    .cmd_nx_o(cmd_nx), .sup_nx_o(sup_nx), .cmd_q_o(cmd_q), .sup_q_o(sup_q)
  );

  pwm_edge_gen #(.CNT_W(CNT_W), .MAX_PCT(MAX_PCT)) u_edge (
    .clk(clk), .rst(rst), .wrap_i(wrap), .cnt_nx_i(cnt_nx), .per_nx_i(per_nx),
    .cmd_nx_i(cmd_nx), .sup_nx_i(sup_nx), .pwm_o(pwm_o), .start_o(start_o)
  );

  // R4
  ready_high_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready_o);

  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start_o |-> ($stable(cmd_q) && $stable(per_q)));

  // R5
  suppress_low_chk: assert property (@(posedge clk) disable iff (rst)
    sup_q |-> !pwm_o);

  // R6
  clamp_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_o |-> ((PW'(cnt_q) * PW'(PCT_FULL)) < (PW'(per_q) * PW'(MAX_PCT))));

  // R2
  start_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (cnt_q == '0));
endmodule

// File: tb/pwm_trail_gen_test.sv
module pwm_trail_gen_test;
  localparam int CW = 16;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [CW-1:0] cmd_data = '0;
  logic [CW-1:0] period = 16'd100;
  logic          pwm, start;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int m_len, m_hi;

  // behavioural reference state
  int r_cnt, r_per, r_cmd, r_pend;
  bit r_pwm, r_start;

  pwm_trail_gen #(.CNT_W(CW), .DEF_PERIOD(200)) uut (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_data_i(cmd_data), .period_i(period), .pwm_o(pwm), .start_o(start)
  );

  always #2 clk = ~clk;

  function automatic int on_len(int c, int p);
    int lim;
    if (c * 100 < p * 2) return 0;
    lim = (40 * p + 99) / 100;
    return (c < lim) ? c : lim;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      r_cnt = 199; r_per = 200; r_cmd = 0; r_pend = 0;
      r_pwm = 0; r_start = 0;
    end else begin
      int sel;
      bit w;
      sel = cmd_valid ? int'(cmd_data) : r_pend;
      if (cmd_valid) r_pend = int'(cmd_data);
      w = (r_cnt == r_per - 1);
      if (w) begin
        r_cnt = 0;
        r_per = (period < 2) ? 2 : int'(period);
        r_cmd = sel;
      end else begin
        r_cnt = r_cnt + 1;
      end
      r_start = w;
      r_pwm = (r_cnt < on_len(r_cmd, r_per));
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    check(pwm === r_pwm, "R3 pwm vs model", int'(pwm), int'(r_pwm));
    check(start === r_start, "R2 start vs model", int'(start), int'(r_start));
    check(cmd_ready === 1'b1, "R4 ready", int'(cmd_ready), 1);
    if (cyc >= WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic measure();
    @(negedge clk);
    while (!start) @(negedge clk);
    m_len = 0; m_hi = 0;
    do begin
      m_len++;
      if (pwm) m_hi++;
      @(negedge clk);
    end while (!start);
  endtask

  task automatic apply(int c, int p);
    cmd_data = CW'(c);
    cmd_valid = 1'b1;
    period = CW'(p);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_case(int c, int p, int exp_len, int exp_hi, string tag);
    apply(c, p);
    measure();
    check(m_len == exp_len, {tag, " period length"}, m_len, exp_len);
    check(m_hi == exp_hi, {tag, " on cycles"}, m_hi, exp_hi);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pwm == 1'b0, "R1 pwm in reset", int'(pwm), 0);
    check(start == 1'b0, "R1 start in reset", int'(start), 0);
    rst = 1'b0;
    @(negedge clk);
    check(start == 1'b1, "R1 first cycle strobe", int'(start), 1);

    run_case(30, 100, 100, 30, "R7 mid command");
    run_case(0, 100, 100, 0, "R5 zero command");
    run_case(1, 100, 100, 0, "R5 inside dead zone");
    run_case(2, 100, 100, 2, "R5 dead zone edge");
    run_case(40, 100, 100, 40, "R6 at limit");
    run_case(41, 100, 100, 40, "R6 just above limit");
    run_case(90, 100, 100, 40, "R6 far above limit");
    run_case(5, 1, 2, 1, "R8 short period");
    run_case(3, 0, 2, 1, "R8 zero period");
    run_case(20, 250, 250, 20, "R7 long period");
    run_case(4, 250, 250, 0, "R5 long period dead zone");
    run_case(60000, 50, 50, 20, "R6 huge command");

    // R4: transfer in the middle of a period leaves the running pulse alone
    run_case(30, 100, 100, 30, "R4 setup");
    while (!start) @(negedge clk);
    m_hi = 0;
    for (int i = 0; i < 10; i++) begin
      if (pwm) m_hi++;
      @(negedge clk);
    end
    cmd_data = 16'd70; cmd_valid = 1'b1;
    if (pwm) m_hi++;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!start) begin
      if (pwm) m_hi++;
      @(negedge clk);
    end
    check(m_hi == 30, "R4 running pulse unchanged", m_hi, 30);
    m_len = 0; m_hi = 0;
    do begin
      m_len++;
      if (pwm) m_hi++;
      @(negedge clk);
    end while (!start);
    check(m_hi == 40, "R4 new command next period", m_hi, 40);

    // R4: last of several transfers in one period wins
    cmd_data = 16'd10; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_data = 16'd25;
    @(negedge clk);
    cmd_valid = 1'b0;
    measure();
    check(m_hi == 25, "R4 last transfer wins", m_hi, 25);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule